// File: doc/BRIEF.md
# Warp-Uniform Load Prefetcher

This block watches the load stream of a warp scheduler and picks out loads whose address is the same in every active lane of the warp. Such loads tend to repeat at the same address on every pass of a loop. The block records each one by its program counter and, when the right load comes round again, sends the recorded address to a prefetch queue so that the data is on its way before the next pass needs it.

Each tracked load has a trigger PC, which is the load that launches its prefetch. At first the trigger is the load itself. A prefetch that is still outstanding when the demand load arrives is late. In that case the block marks the entry slow and moves the trigger one load further back in the recent load sequence. It takes that PC from a short history of recent load PCs. This repeats on later passes until the data comes back before the demand. A return indication, matched by address, tells the block which outstanding prefetch has completed.

The prefetch output is a single registered slot with a valid/ready handshake. A prefetch that finds the slot occupied and not being drained is dropped.

Top module: `tia_prefetcher`

## Requirements
- R1: A load is treated as warp-uniform only if at least one lane is active (`ld_mask` bit set) and every active lane carries the same address. Inactive lanes are ignored. A load with an empty mask, or with differing active addresses, neither allocates nor updates a table entry.
- R2: A uniform load whose PC is not in the table allocates an entry. The entry's tag and trigger are both that PC and it stores the uniform address. A later execution of that PC then issues the stored address.
- R3: Any valid load, uniform or not, whose PC equals the trigger PC of a valid entry issues that entry's stored address. The address appears on `pf_addr` with `pf_valid` high from the clock edge that takes the load. If several entries match, the lowest entry index wins. The entry becomes outstanding.
- R4: A uniform load that hits its own entry while that entry's prefetch is outstanding, with no matching return in the same cycle, is late. It sets the slow bit. If the entry's depth d is below the number of loads recorded in the history (at most 4), d becomes d+1. The trigger then becomes the PC of the load executed d+1 loads before this one, where 1 means the immediately preceding load. Otherwise the trigger is left unchanged.
- R5: A demand hit that is not late leaves the trigger and depth unchanged. Repeated late passes keep moving the trigger back one load each time, until a pass is timely or the depth limit is reached.
- R6: `ret_valid` with `ret_addr` equal to the stored address of an outstanding entry ends that entry's outstanding state and clears its slow bit. A return in the same cycle as the demand load counts as timely.
- R7: The table holds 8 entries. Allocation fills them in round-robin order starting at entry 0, and the ninth distinct PC evicts the oldest allocation.
- R8: While `pf_valid` is high and `pf_ready` is low, `pf_valid` and `pf_addr` hold. A trigger in such a cycle is dropped and leaves its entry not outstanding.
- R9: After synchronous reset the table is empty and `pf_valid` is low.
- R10: Every demand hit stores the current uniform address in the entry. The address is used from the entry's next trigger onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A load issues this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | LANES*ADDR_W | Per-lane addresses, lane 0 in the low bits |
| ld_mask | input | LANES | Active-lane mask, bit l for lane l |
| ret_valid | input | 1 | A prefetched line has returned |
| ret_addr | input | ADDR_W | Address of the returned prefetch |
| pf_ready | input | 1 | Prefetch queue accepts the presented address |
| pf_valid | output | 1 | Prefetch address is presented |
| pf_addr | output | ADDR_W | Prefetch address |

## Verification
Directed passes first take one loop with fully uniform lanes, then lanes that agree only under the mask, then lanes that disagree, then an empty mask. This separates uniform detection from the trigger path. A loop of four loads run with no returns shows the trigger walking back one load per pass until the depth limit. The same loop run with returns, including a return in the demand cycle, tells late passes from timely ones. Nine distinct PCs show round-robin eviction. Triggers against a stalled queue show that dropped requests do not later count as late. Constrained random traffic then mixes a small PC set, partial masks, returns and ready gaps, and checks every cycle against the bench model.

// File: rtl/tia_pkg.sv
package tia_pkg;
  typedef enum logic [1:0] {
    DM_NONE  = 2'd0,
    DM_TIMELY = 2'd1,
    DM_LATE  = 2'd2,
    DM_ALLOC = 2'd3
  } demand_kind_e;
endpackage

// File: rtl/tia_uniform_detect.sv
module tia_uniform_detect #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32
) (
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  input  logic [LANES-1:0]        lane_mask,
  output logic                    uniform,
  output logic [ADDR_W-1:0]       uaddr
);
  logic found;
  logic same;

  always_comb begin
    found = 1'b0;
    uaddr = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_mask[l] && !found) begin
        uaddr = lane_addr[l*ADDR_W +: ADDR_W];
        found = 1'b1;
      end
    end
    same = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (lane_mask[l] && (lane_addr[l*ADDR_W +: ADDR_W] != uaddr)) same = 1'b0;
    end
    uniform = found && same;
  end

  // R1: a uniform verdict needs at least one active lane
  always_comb begin
    if (uniform) assert (lane_mask != '0) else $error("assert_uniform_mask_R1");
  end
endmodule

// File: rtl/tia_pc_history.sv
module tia_pc_history #(
  parameter int PC_W = 16,
  parameter int HIST = 4,
  localparam int DW = $clog2(HIST + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld_valid,
  input  logic [PC_W-1:0]           ld_pc,
  output logic [HIST-1:0][PC_W-1:0] hist,
  output logic [DW-1:0]             hcnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      hcnt <= '0;
    end else if (ld_valid) begin
      for (int k = HIST - 1; k > 0; k--) hist[k] <= hist[k-1];
      hist[0] <= ld_pc;
      if (hcnt != DW'(HIST)) hcnt <= hcnt + 1'b1;
    end
  end

  // R4: the most recent history slot is the previous load PC
  assert_hist_shift_R4: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> hist[0] == $past(ld_pc));
endmodule

// File: rtl/tia_table.sv
module tia_table
  import tia_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PC_W    = 16,
  parameter int ADDR_W  = 32,
  parameter int HIST    = 4,
  localparam int DW = $clog2(HIST + 1),
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld_valid,
  input  logic [PC_W-1:0]           ld_pc,
  input  logic                      uniform,
  input  logic [ADDR_W-1:0]         uaddr,
  input  logic [HIST-1:0][PC_W-1:0] hist,
  input  logic [DW-1:0]             hcnt,
  input  logic                      ret_valid,
  input  logic [ADDR_W-1:0]         ret_addr,
  input  logic                      slot_free,
  output logic                      push,
  output logic [ADDR_W-1:0]         push_addr
);
  logic [ENTRIES-1:0] vld_q, pend_q, slow_q;
  logic [PC_W-1:0]    tag_q  [ENTRIES];
  logic [PC_W-1:0]    trig_q [ENTRIES];
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [DW-1:0]      dep_q  [ENTRIES];
  logic [IW-1:0]      rr_q;

  logic [ENTRIES-1:0] ret_hit;
  logic               tfire, dhit, alloc, late;
  logic [IW-1:0]      tidx, didx;
  logic [DW-1:0]      new_dep;
  logic [PC_W-1:0]    new_trig;
  demand_kind_e       dkind;

  always_comb begin
    tfire = 1'b0;
    tidx  = '0;
    dhit  = 1'b0;
    didx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      ret_hit[i] = ret_valid && vld_q[i] && pend_q[i] && (addr_q[i] == ret_addr);
      if (ld_valid && vld_q[i] && trig_q[i] == ld_pc) begin
        tfire = 1'b1;
        tidx  = IW'(i);
      end
      if (ld_valid && uniform && vld_q[i] && tag_q[i] == ld_pc) begin
        dhit = 1'b1;
        didx = IW'(i);
      end
    end
    alloc   = ld_valid && uniform && !dhit;
    late    = dhit && pend_q[didx] && !ret_hit[didx];
    new_dep = (dep_q[didx] < hcnt) ? dep_q[didx] + 1'b1 : dep_q[didx];
    new_trig = (new_dep != '0) ? hist[DW'(new_dep - 1'b1)] : trig_q[didx];
    if (alloc)     dkind = DM_ALLOC;
    else if (late) dkind = DM_LATE;
    else if (dhit) dkind = DM_TIMELY;
    else           dkind = DM_NONE;
    push      = tfire && slot_free;
    push_addr = addr_q[tidx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      pend_q <= '0;
      slow_q <= '0;
      rr_q   <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ret_hit[i]) begin
          pend_q[i] <= 1'b0;
          slow_q[i] <= 1'b0;
        end
      end
      case (dkind)
        DM_LATE: begin
          addr_q[didx] <= uaddr;
          pend_q[didx] <= 1'b0;
          slow_q[didx] <= 1'b1;
          if (new_dep != dep_q[didx]) begin
            dep_q[didx]  <= new_dep;
            trig_q[didx] <= new_trig;
          end
        end
        DM_TIMELY: begin
          addr_q[didx] <= uaddr;
          pend_q[didx] <= 1'b0;
        end
        DM_ALLOC: begin
          vld_q[rr_q]  <= 1'b1;
          tag_q[rr_q]  <= ld_pc;
          trig_q[rr_q] <= ld_pc;
          addr_q[rr_q] <= uaddr;
          dep_q[rr_q]  <= '0;
          pend_q[rr_q] <= 1'b0;
          slow_q[rr_q] <= 1'b0;
          rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
        default: ;
      endcase
      if (push && !(alloc && rr_q == tidx)) pend_q[tidx] <= 1'b1;
    end
  end

  // R7: each allocation advances the replacement pointer by one
  assert_rr_step_R7: assert property (@(posedge clk) disable iff (rst)
    alloc |=> rr_q == (($past(rr_q) == IW'(ENTRIES - 1)) ? '0 : $past(rr_q) + 1'b1));

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
      // R6: a matching return leaves the entry not slow
      assert_slow_clear_R6: assert property (@(posedge clk) disable iff (rst)
        ret_hit[g] |=> !slow_q[g]);
    end
  endgenerate
endmodule

// File: rtl/tia_pf_out.sv
module tia_pf_out #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pf_ready,
  output logic              slot_free,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  assign slot_free = !pf_valid || pf_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (push) begin
      pf_valid <= 1'b1;
      pf_addr  <= push_addr;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end

  // R8: a stalled request holds
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));
  // R3: an accepted trigger appears at the output
  assert_push_visible_R3: assert property (@(posedge clk) disable iff (rst)
    push |=> (pf_valid && pf_addr == $past(push_addr)));
endmodule

// File: rtl/tia_prefetcher.sv
module tia_prefetcher #(
  parameter int LANES   = 4,
  parameter int ADDR_W  = 32,
  parameter int PC_W    = 16,
  parameter int ENTRIES = 8,
  parameter int HIST    = 4,
  localparam int DW = $clog2(HIST + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_valid,
  input  logic [PC_W-1:0]         ld_pc,
  input  logic [LANES*ADDR_W-1:0] ld_addr,
  input  logic [LANES-1:0]        ld_mask,
  input  logic                    ret_valid,
  input  logic [ADDR_W-1:0]       ret_addr,
  input  logic                    pf_ready,
  output logic                    pf_valid,
  output logic [ADDR_W-1:0]       pf_addr
);
  logic                      uniform;
  logic [ADDR_W-1:0]         uaddr;
  logic [HIST-1:0][PC_W-1:0] hist;
  logic [DW-1:0]             hcnt;
  logic                      slot_free, push;
  logic [ADDR_W-1:0]         push_addr;

  tia_uniform_detect #(.LANES(LANES), .ADDR_W(ADDR_W)) u_detect (
    .lane_addr(ld_addr), .lane_mask(ld_mask), .uniform(uniform), .uaddr(uaddr));

  tia_pc_history #(.PC_W(PC_W), .HIST(HIST)) u_hist (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_pc(ld_pc), .hist(hist), .hcnt(hcnt));

  tia_table #(.ENTRIES(ENTRIES), .PC_W(PC_W), .ADDR_W(ADDR_W), .HIST(HIST)) u_table (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_pc(ld_pc), .uniform(uniform),
    .uaddr(uaddr), .hist(hist), .hcnt(hcnt), .ret_valid(ret_valid), .ret_addr(ret_addr),
    .slot_free(slot_free), .push(push), .push_addr(push_addr));

  tia_pf_out #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .push(push), .push_addr(push_addr), .pf_ready(pf_ready),
    .slot_free(slot_free), .pf_valid(pf_valid), .pf_addr(pf_addr));
endmodule

// File: tb/tia_prefetcher_bench.sv
module tia_prefetcher_bench;
  localparam int NE = 8;
  localparam int NH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_pc = '0;
  logic [127:0] ld_addr = '0;
  logic [3:0]  ld_mask = '0;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_addr = '0;
  logic        pf_ready = 1'b1;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tia_prefetcher u_tia_prefetcher (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_addr(ld_addr),
    .ld_mask(ld_mask), .ret_valid(ret_valid), .ret_addr(ret_addr), .pf_ready(pf_ready),
    .pf_valid(pf_valid), .pf_addr(pf_addr));

  // bench model of the table
  bit          m_v [NE];
  bit          m_pend [NE];
  logic [15:0] m_tag [NE];
  logic [15:0] m_trig [NE];
  logic [31:0] m_addr [NE];
  int          m_dep [NE];
  int          m_rr;
  logic [15:0] m_hist [NH];
  int          m_hcnt;
  bit          e_v;
  logic [31:0] e_a;

  function automatic logic [127:0] uni(input logic [31:0] a);
    return {a, a, a, a};
  endfunction

  function automatic bit is_uni(input logic [127:0] la, input logic [3:0] mk,
                                output logic [31:0] ua);
    bit found = 0;
    ua = '0;
    for (int l = 0; l < 4; l++) if (mk[l] && !found) begin ua = la[l*32 +: 32]; found = 1; end
    for (int l = 0; l < 4; l++) if (mk[l] && la[l*32 +: 32] != ua) return 0;
    return found;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_pend[i] = 0; m_dep[i] = 0; end
    for (int k = 0; k < NH; k++) m_hist[k] = '0;
    m_rr = 0; m_hcnt = 0; e_v = 0; e_a = '0;
  endtask

  task automatic model_step(input bit lv, input logic [15:0] pc, input logic [127:0] la,
                            input logic [3:0] mk, input bit rv, input logic [31:0] ra,
                            input bit rdy);
    bit rh [NE];
    bit u, tf, dh, al, lt, psh;
    int ti, di, nd;
    logic [31:0] ua;
    u = is_uni(la, mk, ua);
    tf = 0; ti = 0; dh = 0; di = 0;
    for (int i = NE - 1; i >= 0; i--) begin
      rh[i] = rv && m_v[i] && m_pend[i] && m_addr[i] == ra;
      if (lv && m_v[i] && m_trig[i] == pc) begin tf = 1; ti = i; end
      if (lv && u && m_v[i] && m_tag[i] == pc) begin dh = 1; di = i; end
    end
    al = lv && u && !dh;
    lt = dh && m_pend[di] && !rh[di];
    psh = tf && (!e_v || rdy);
    if (psh) e_a = m_addr[ti];
    for (int i = 0; i < NE; i++) if (rh[i]) m_pend[i] = 0;
    if (dh) begin
      if (lt && m_dep[di] < m_hcnt) begin
        nd = m_dep[di] + 1;
        m_trig[di] = m_hist[nd-1];
        m_dep[di] = nd;
      end
      m_addr[di] = ua;
      m_pend[di] = 0;
    end
    if (psh && !(al && m_rr == ti)) m_pend[ti] = 1;
    if (al) begin
      m_v[m_rr] = 1; m_tag[m_rr] = pc; m_trig[m_rr] = pc; m_addr[m_rr] = ua;
      m_dep[m_rr] = 0; m_pend[m_rr] = 0;
      m_rr = (m_rr + 1) % NE;
    end
    if (psh) e_v = 1; else if (rdy) e_v = 0;
    if (lv) begin
      for (int k = NH - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = pc;
      if (m_hcnt < NH) m_hcnt++;
    end
  endtask

  task automatic check_out(input string tag);
    total++;
    if (pf_valid !== e_v || (e_v && pf_addr !== e_a)) begin
      bad++;
      $display("FAIL %s got v=%0b a=%h exp v=%0b a=%h", tag, pf_valid, pf_addr, e_v, e_a);
    end
  endtask

  task automatic step(input bit lv, input logic [15:0] pc, input logic [127:0] la,
                      input logic [3:0] mk, input bit rv, input logic [31:0] ra,
                      input bit rdy, input string tag);
    ld_valid = lv; ld_pc = pc; ld_addr = la; ld_mask = mk;
    ret_valid = rv; ret_addr = ra; pf_ready = rdy;
    model_step(lv, pc, la, mk, rv, ra, rdy);
    @(posedge clk);
    #2;
    check_out(tag);
  endtask

  task automatic ld(input logic [15:0] pc, input logic [127:0] la, input logic [3:0] mk,
                    input string tag);
    step(1, pc, la, mk, 0, '0, 1, tag);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL R9 watchdog got=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    check_out("R9 reset");
    // R2 / R3: allocate, then trigger on re-execution
    ld(16'd5, uni(32'h1000), 4'hf, "R2 alloc");
    ld(16'd5, uni(32'h1000), 4'hf, "R3 trigger");
    step(0, '0, '0, '0, 1, 32'h1000, 1, "R6 return");
    ld(16'd5, uni(32'h1000), 4'hf, "R5 timely");
    // R1: differing lanes, masked agreement, empty mask
    ld(16'd7, {32'h1, 32'h2, 32'h3, 32'h4}, 4'hf, "R1 differ");
    ld(16'd7, {32'h9, 32'h7000, 32'h8, 32'h7000}, 4'b0101, "R1 masked");
    ld(16'd7, {32'h1, 32'h2, 32'h3, 32'h4}, 4'hf, "R1 trig nonuni");
    ld(16'd8, uni(32'h8000), 4'h0, "R1 empty");
    ld(16'd8, uni(32'h8000), 4'hf, "R1 empty after");
    // R10: new address stored on demand
    ld(16'd5, uni(32'h1500), 4'hf, "R10 update");
    ld(16'd5, uni(32'h1500), 4'hf, "R10 new addr");
    // R4 / R5: late loop walks the trigger back
    for (int it = 0; it < 7; it++) begin
      ld(16'd20, {32'h1, 32'h2, 32'h3, 32'h4}, 4'hf, "R4 loop");
      ld(16'd21, '0, 4'h0, "R4 loop");
      ld(16'd22, {32'h5, 32'h6, 32'h7, 32'h8}, 4'hf, "R4 loop");
      ld(16'd23, uni(32'h2300), 4'hf, "R4 late");
    end
    for (int it = 0; it < 3; it++) begin
      ld(16'd20, {32'h1, 32'h2, 32'h3, 32'h4}, 4'hf, "R5 loop");
      step(1, 16'd21, '0, 4'h0, 1, 32'h2300, 1, "R5 ret");
      ld(16'd22, {32'h5, 32'h6, 32'h7, 32'h8}, 4'hf, "R5 loop");
      step(1, 16'd23, uni(32'h2300), 4'hf, 1, 32'h2300, 1, "R5 timely");
    end
    // R8: stall and drop
    ld(16'd5, uni(32'h1500), 4'hf, "R8 push");
    step(1, 16'd5, uni(32'h1500), 4'hf, 0, '0, 0, "R8 hold");
    step(1, 16'd7, uni(32'h7000), 4'hf, 0, '0, 0, "R8 drop");
    step(0, '0, '0, '0, 0, '0, 1, "R8 drain");
    ld(16'd7, uni(32'h7000), 4'hf, "R8 not late");
    // R7: nine distinct PCs
    for (int p = 0; p < 9; p++) ld(16'(40 + p), uni(32'(32'h4000 + p * 16)), 4'hf, "R7 fill");
    for (int p = 0; p < 9; p++) ld(16'(40 + p), '0, 4'h0, "R7 probe");
    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [127:0] la;
      logic [31:0]  a;
      logic [3:0]   mk;
      a = 32'h100 * ($urandom % 6);
      if ($urandom % 4 != 0) la = uni(a);
      else la = {32'h100 * ($urandom % 6), a, 32'h100 * ($urandom % 6), a};
      mk = 4'($urandom);
      step(($urandom % 5) != 0, 16'($urandom % 12), la, mk, ($urandom % 3) == 0,
           32'h100 * ($urandom % 6), ($urandom % 4) != 0, "R3 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule